// File: doc/BRIEF.md
# Token-Ring Depth Cascade FIFO

This block builds one deep first-in first-out queue out of several identical small FIFO slices. The slices sit in a closed ring. Two tokens travel around that ring. The write token marks the only slice that may store the incoming word. The read token marks the only slice that may present its oldest word on the shared output. A slice that has just used its last storage location hands the matching token to the next slice in the ring. The handover uses a one-cycle cascade pulse, and no write or read cycle is lost while the token moves.

Each slice has a first-load strap. The slice whose strap is low starts with both tokens after reset. The straps of all other slices are high, so they start with no token. The queue holds DEVICES × SLOT_DEPTH words of WIDTH bits. The word width does not change with the number of slices.

Each token is kept by a small two-state machine in every slice. The states are TOK_IDLE, where the slice does not hold the token, and TOK_HELD, where it does. Each machine has two transitions:
- TOK_IDLE → TOK_HELD when the cascade input from the previous slice pulses.
- TOK_HELD → TOK_IDLE when the slice completes an operation on its last location and the slice is not taking the token back in the same cycle.

The reset state is TOK_HELD when the first-load strap is low and TOK_IDLE when it is high. A single clock drives both the write side and the read side.

Top module: `casc_fifo_ring`

## Requirements
- R1: After reset, slice 0 (the only slice with its first-load strap low) holds both tokens. `wr_owner` and `rd_owner` both equal 1 (bit 0 set), `empty` is 1 and `full` is 0.
- R2: At every cycle, exactly one bit of `wr_owner` is set and exactly one bit of `rd_owner` is set. Only the read-token slice drives `rd_data`.
- R3: The write token moves from slice i to slice (i+1) mod DEVICES at the clock edge where slice i accepts a write into its last location. That is every SLOT_DEPTH accepted writes, and the move from the last slice back to slice 0 closes the ring.
- R4: The read token moves from slice i to slice (i+1) mod DEVICES at the clock edge where slice i accepts a read of its last location. That is every SLOT_DEPTH accepted reads, and it wraps from the last slice back to slice 0.
- R5: A token moves only on an accepted operation. A write while `full` is high, or a read while `empty` is high, leaves both owner vectors unchanged.
- R6: Words leave in the exact order they were accepted, across slice boundaries and across the wrap from the last slice to slice 0.
- R7: `full` is 1 exactly when DEVICES × SLOT_DEPTH words are stored. A write while `full` is high stores nothing.
- R8: `empty` is 1 exactly when no word is stored. A read while `empty` is high removes nothing. While `empty` is 0, `rd_data` shows the oldest stored word in the same cycle.
- R9: A write and a read asserted in the same cycle, when neither `full` nor `empty` blocks them, are both accepted at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and read sides |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | The write-token slice has no free location |
| rd_en | input | 1 | Read request; removes the word shown on rd_data |
| rd_data | output | WIDTH | Oldest word, driven only by the read-token slice |
| empty | output | 1 | The read-token slice holds no word |
| wr_owner | output | DEVICES | One-hot vector of the slice holding the write token |
| rd_owner | output | DEVICES | One-hot vector of the slice holding the read token |

## Verification
The hardest case to reach is the write token coming round the ring into the slice that the read token still occupies. That slice then holds old words in its upper locations and new words in its lower ones, so the order of the output depends on the read token leaving and coming back. The stimulus table first fills the ring past capacity. It then drains part of it, and then runs simultaneous writes and reads so that both tokens keep moving round the ring. This way each token wraps from the last slice to slice 0 several times while the other token sits in the slice being entered. A final drain with extra reads checks that the words come out in order and that the owner vectors stay unchanged at empty.

// File: rtl/casc_pkg.sv
package casc_pkg;
    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_HELD = 1'b1
    } tok_state_t;
endpackage

// File: rtl/casc_token.sv
module casc_token
    import casc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_load_n,
    input  logic take_in,
    input  logic act,
    input  logic at_last,
    output logic held,
    output logic pass_out
);
    tok_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= first_load_n ? TOK_IDLE : TOK_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        held     = (state_q == TOK_HELD);
        pass_out = held && act && at_last;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_IDLE: if (take_in)              state_d = TOK_HELD;
            TOK_HELD: if (pass_out && !take_in) state_d = TOK_IDLE;
            default:                            state_d = TOK_IDLE;
        endcase
    end
endmodule

// File: rtl/casc_store.sv
module casc_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             is_full,
    output logic             is_empty,
    output logic             wr_at_last,
    output logic             rd_at_last
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        head       = mem[rd_ptr];
        is_full    = (count == CNT_W'(DEPTH));
        is_empty   = (count == '0);
        wr_at_last = (wr_ptr == LAST);
        rd_at_last = (rd_ptr == LAST);
    end
endmodule

// File: rtl/casc_node.sv
module casc_node #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_load_n,
    input  logic             wr_casc_in,
    output logic             wr_casc_out,
    input  logic             rd_casc_in,
    output logic             rd_casc_out,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             has_wr,
    output logic             has_rd,
    output logic             node_full,
    output logic             node_empty
);
    logic             do_wr, do_rd, wr_last, rd_last;
    logic [WIDTH-1:0] head;

    always_comb begin
        do_wr   = wr_req && has_wr;
        do_rd   = rd_req && has_rd;
        rd_data = has_rd ? head : '0;
    end

    casc_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(do_wr), .push_data(wr_data), .pop(do_rd),
        .head(head), .is_full(node_full), .is_empty(node_empty),
        .wr_at_last(wr_last), .rd_at_last(rd_last)
    );

    casc_token u_wtok (
        .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
        .take_in(wr_casc_in), .act(do_wr), .at_last(wr_last),
        .held(has_wr), .pass_out(wr_casc_out)
    );

    casc_token u_rtok (
        .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
        .take_in(rd_casc_in), .act(do_rd), .at_last(rd_last),
        .held(has_rd), .pass_out(rd_casc_out)
    );
endmodule

// File: rtl/casc_fifo_ring.sv
module casc_fifo_ring #(
    parameter int DEVICES    = 3,
    parameter int SLOT_DEPTH = 4,
    parameter int WIDTH      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WIDTH-1:0]   wr_data,
    output logic               full,
    input  logic               rd_en,
    output logic [WIDTH-1:0]   rd_data,
    output logic               empty,
    output logic [DEVICES-1:0] wr_owner,
    output logic [DEVICES-1:0] rd_owner
);
    logic [DEVICES-1:0]            wr_pass, rd_pass, n_full, n_empty;
    logic [DEVICES-1:0][WIDTH-1:0] n_data;
    logic                          wr_req, rd_req;

    always_comb begin
        full   = |(wr_owner & n_full);
        empty  = |(rd_owner & n_empty);
        wr_req = wr_en && !full;
        rd_req = rd_en && !empty;
    end

    for (genvar i = 0; i < DEVICES; i++) begin : g_ring
        localparam int PREV = (i == 0) ? DEVICES - 1 : i - 1;
        casc_node #(.WIDTH(WIDTH), .DEPTH(SLOT_DEPTH)) u_node (
            .clk(clk), .rst_n(rst_n),
            .first_load_n(i != 0),
            .wr_casc_in(wr_pass[PREV]), .wr_casc_out(wr_pass[i]),
            .rd_casc_in(rd_pass[PREV]), .rd_casc_out(rd_pass[i]),
            .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
            .rd_data(n_data[i]),
            .has_wr(wr_owner[i]), .has_rd(rd_owner[i]),
            .node_full(n_full[i]), .node_empty(n_empty[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEVICES; k++) rd_data |= n_data[k];
    end
endmodule

// File: rtl/casc_ring_chk.sv
module casc_ring_chk #(
    parameter int DEVICES = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic               full,
    input logic               empty,
    input logic [DEVICES-1:0] wr_owner,
    input logic [DEVICES-1:0] rd_owner
);
    function automatic logic [DEVICES-1:0] step_ring(input logic [DEVICES-1:0] v);
        logic [DEVICES-1:0] r;
        for (int k = 0; k < DEVICES; k++) r[(k + 1) % DEVICES] = v[k];
        return r;
    endfunction

    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_owner) == 1);
    // R2
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_owner) == 1);
    // R3
    wr_ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> (wr_owner == $past(wr_owner)) || (wr_owner == step_ring($past(wr_owner))));
    // R4
    rd_ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty) |=> (rd_owner == $past(rd_owner)) || (rd_owner == step_ring($past(rd_owner))));
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || full) |=> $stable(wr_owner));
    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || empty) |=> $stable(rd_owner));
    // R7
    no_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind casc_fifo_ring casc_ring_chk #(.DEVICES(DEVICES)) u_ring_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .wr_owner(wr_owner), .rd_owner(rd_owner)
);

// File: tb/tb_casc_fifo_ring.sv
module tb_casc_fifo_ring;
    localparam int N   = 3;
    localparam int D   = 4;
    localparam int W   = 8;
    localparam int CAP = N * D;
    localparam int NOPS = 8;
    // each entry: {repeat count, wr_en, rd_en}
    localparam logic [9:0] OPS [NOPS] = '{
        {8'd14, 2'b10}, {8'd5, 2'b01}, {8'd6, 2'b11}, {8'd16, 2'b01},
        {8'd9,  2'b10}, {8'd9, 2'b11}, {8'd20, 2'b01}, {8'd3, 2'b00}
    };

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic full, empty;
    logic [W-1:0] rd_data;
    logic [N-1:0] wr_owner, rd_owner;

    int checks = 0, errors = 0;
    int q[$];
    int wtot = 0, rtot = 0, next_val = 8'h30;
    bit done = 1'b0;

    always #2 clk = ~clk;

    casc_fifo_ring #(.DEVICES(N), .SLOT_DEPTH(D), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
        .wr_owner(wr_owner), .rd_owner(rd_owner)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        q.delete(); wtot = 0; rtot = 0;
        #1;
        chk(wr_owner == 3'b001, "R1", int'(wr_owner), 1);
        chk(rd_owner == 3'b001, "R1", int'(rd_owner), 1);
        chk(empty == 1'b1 && full == 1'b0, "R1", int'({full, empty}), 1);
    endtask

    task automatic step(input logic w, input logic r);
        bit ef, ee, aw, ar;
        int ew, er;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = W'(next_val);
        #1;
        ef = (q.size() == CAP);
        ee = (q.size() == 0);
        ew = (wtot / D) % N;
        er = (rtot / D) % N;
        aw = w && !ef;
        ar = r && !ee;
        chk(full == ef, "R7", int'(full), int'(ef));
        chk(empty == ee, "R8", int'(empty), int'(ee));
        chk($countones(wr_owner) == 1 && $countones(rd_owner) == 1, "R2",
            int'({wr_owner, rd_owner}), 0);
        chk(wr_owner == N'(1 << ew), (w && ef) ? "R5" : "R3", int'(wr_owner), 1 << ew);
        chk(rd_owner == N'(1 << er), (r && ee) ? "R5" : "R4", int'(rd_owner), 1 << er);
        if (!ee)
            chk(rd_data == W'(q[0]), (aw && ar) ? "R9" : "R6", int'(rd_data), q[0]);
        if (ar) begin void'(q.pop_front()); rtot++; end
        if (aw) begin q.push_back(next_val & 8'hff); wtot++; next_val++; end
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NOPS; i++)
            for (int j = 0; j < int'(OPS[i][9:2]); j++)
                step(OPS[i][1], OPS[i][0]);
        // reset in the middle of a partly filled ring: R1
        for (int j = 0; j < 6; j++) step(1'b1, 1'b0);
        do_reset();
        // single word then immediate read: R8 and R6
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule